// File: doc/BRIEF.md
# Burst Acknowledge Ignore-State Sequencer

This block is the termination sequencer of a bus master that moves data in burst line transfers or in single transfers. At the start of every beat it loads a programmable ignore count into a down-counter. While that counter is nonzero the incoming transfer acknowledge is masked, even if it is already high. Once the counter reaches zero the block raises a sampling status output and accepts the acknowledge on each clock. If the acknowledge has not yet arrived, the block keeps inserting wait states until it does. The first beat of a transfer takes its count from a primary register. Each later beat of a line reloads from a secondary register. Reads and writes each have their own pair of registers.

The four count registers are captured from their inputs on every clock while reset is asserted and then hold their values. A start strobe in idle launches a transfer. A line has a fixed number of beats; a single transfer has one beat. Each accepted acknowledge pulses the data-latch enable and beat-done. After the final beat, line-done pulses for one clock and the sequencer returns to idle.

The state machine has four states. The states are ST_IDLE, ST_HOLD (counting, acknowledge masked), ST_SAMPLE (acknowledge sampled) and ST_LINE_END (line-done pulse). The transitions are as follows:
- ST_IDLE goes to ST_HOLD on a start with a nonzero count, or to ST_SAMPLE on a start with a zero count.
- ST_HOLD goes to ST_SAMPLE when the counter steps from one to zero.
- ST_SAMPLE stays in ST_SAMPLE without acknowledge. On acknowledge it goes to ST_LINE_END after the last beat. After any other beat it goes to ST_HOLD or ST_SAMPLE, depending on whether the next count is nonzero or zero.
- ST_LINE_END always returns to ST_IDLE.

Top module: `ack_gate_seq`

## Requirements
- R1: While rst_n is low all outputs are low and the four count registers capture their inputs on each clock; count inputs that change after reset is released have no effect on any later transfer.
- R2: The first beat of a transfer loads the primary count of its direction (rd_i = 1 selects the read pair, 0 the write pair, sampled with the start); every later beat of the same line loads the secondary count of that direction.
- R3: While the beat's ignore counter is nonzero, ack_i is ignored: latch_o and beat_done_o stay low even with ack_i high.
- R4: The counter decrements once per clock; with a loaded count N, samp_o first goes high in clock N+1 after the start edge (the cycle right after the start edge is clock 1).
- R5: samp_o is high in every cycle in which ack_i is sampled; after an accepted acknowledge it goes low if the next beat's count is nonzero or the transfer ended, and stays high with no gap if the next count is zero.
- R6: Once sampling has begun, the block waits as many clocks as needed; latch_o and beat_done_o are high exactly in the cycles where samp_o and ack_i are both high.
- R7: With burst_i = 1 a transfer has BEATS beats (four by default); with burst_i = 0 it has one beat using only the primary count.
- R8: line_done_o pulses for one clock in the cycle after the final accepted acknowledge, then the block is idle; a start strobe while a transfer is in progress is ignored.
- R9: With primary and secondary counts both 1 and ack_i held high, each beat is latched one clock later than with zero counts: latches fall on clocks 2, 4, 6 and 8 after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; count registers load while low |
| start_i | input | 1 | Transfer start strobe, accepted in idle |
| rd_i | input | 1 | Direction with start: 1 read, 0 write |
| burst_i | input | 1 | With start: 1 line burst, 0 single beat |
| ack_i | input | 1 | Transfer acknowledge from the slave |
| rd_first_cnt_i | input | CW | Read primary ignore count |
| rd_next_cnt_i | input | CW | Read secondary ignore count |
| wr_first_cnt_i | input | CW | Write primary ignore count |
| wr_next_cnt_i | input | CW | Write secondary ignore count |
| latch_o | output | 1 | Data latch enable, high in the accepting cycle |
| samp_o | output | 1 | Acknowledge sampling status |
| beat_done_o | output | 1 | Beat completed this cycle |
| line_done_o | output | 1 | One-clock pulse after the last beat |

## Verification
The bench builds the block with its defaults, CW = 4 and BEATS = 4. The 4-bit counts allow ignore values from zero up to several clocks, so zero, one and multi-clock counts can be set in one reset. Using different read and write pairs shows which pair each beat reloads from. Held, delayed and pseudo-random acknowledge patterns reach both cases: the count expiring before acknowledge, and acknowledge arriving while it is still masked.

// File: rtl/ack_gate_pkg.sv
package ack_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_HOLD     = 2'd1,
        ST_SAMPLE   = 2'd2,
        ST_LINE_END = 2'd3
    } seq_state_t;

    localparam int unsigned NUM_CNT_REGS = 4;
    localparam int unsigned IDX_RD_FIRST = 0;
    localparam int unsigned IDX_RD_NEXT  = 1;
    localparam int unsigned IDX_WR_FIRST = 2;
    localparam int unsigned IDX_WR_NEXT  = 3;

endpackage

// File: rtl/ack_gate_cntregs.sv
module ack_gate_cntregs
    import ack_gate_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CNT_REGS-1:0][CW-1:0]   cnt_in,
    output logic [NUM_CNT_REGS-1:0][CW-1:0]   cnt_q
);

    // Each register follows its input while reset is held and freezes after.
    for (genvar g = 0; g < NUM_CNT_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= cnt_in[g];
            end
        end
    end

endmodule

// File: rtl/ack_gate_cntsel.sv
module ack_gate_cntsel
    import ack_gate_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic                              sel_rd,
    input  logic                              sel_first,
    input  logic [NUM_CNT_REGS-1:0][CW-1:0]   cnt_regs,
    output logic [CW-1:0]                     cnt_sel,
    output logic                              cnt_zero
);

    always_comb begin
        unique case ({sel_rd, sel_first})
            2'b11:   cnt_sel = cnt_regs[IDX_RD_FIRST];
            2'b10:   cnt_sel = cnt_regs[IDX_RD_NEXT];
            2'b01:   cnt_sel = cnt_regs[IDX_WR_FIRST];
            default: cnt_sel = cnt_regs[IDX_WR_NEXT];
        endcase
    end

    assign cnt_zero = (cnt_sel == '0);

endmodule

// File: rtl/ack_gate_down.sv
module ack_gate_down #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt_q,
    output logic          at_one
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign at_one = (cnt_q == ONE);

endmodule

// File: rtl/ack_gate_beats.sv
module ack_gate_beats #(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic burst_in,
    input  logic adv,
    output logic last
);

    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);

    logic [BW-1:0] idx_q;
    logic          burst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            burst_q <= 1'b0;
        end else if (clear) begin
            idx_q   <= '0;
            burst_q <= burst_in;
        end else if (adv) begin
            idx_q   <= idx_q + BW'(1);
        end
    end

    assign last = !burst_q || (idx_q == LAST_IDX);

endmodule

// File: rtl/ack_gate_seq.sv
module ack_gate_seq
    import ack_gate_pkg::*;
#(
    parameter int unsigned CW    = 4,
    parameter int unsigned BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          rd_i,
    input  logic          burst_i,
    input  logic          ack_i,
    input  logic [CW-1:0] rd_first_cnt_i,
    input  logic [CW-1:0] rd_next_cnt_i,
    input  logic [CW-1:0] wr_first_cnt_i,
    input  logic [CW-1:0] wr_next_cnt_i,
    output logic          latch_o,
    output logic          samp_o,
    output logic          beat_done_o,
    output logic          line_done_o
);

    seq_state_t st_q, st_nx;

    logic [NUM_CNT_REGS-1:0][CW-1:0] cnt_in, cnt_regs;
    logic [CW-1:0] cnt_sel, cnt_q;
    logic          cnt_zero, at_one;
    logic          rd_q;
    logic          accept, beat_end, last_beat, load, sel_rd;

    assign cnt_in[IDX_RD_FIRST] = rd_first_cnt_i;
    assign cnt_in[IDX_RD_NEXT]  = rd_next_cnt_i;
    assign cnt_in[IDX_WR_FIRST] = wr_first_cnt_i;
    assign cnt_in[IDX_WR_NEXT]  = wr_next_cnt_i;

    assign accept   = (st_q == ST_IDLE) && start_i;
    assign beat_end = (st_q == ST_SAMPLE) && ack_i;
    assign load     = accept || (beat_end && !last_beat);
    assign sel_rd   = accept ? rd_i : rd_q;

    ack_gate_cntregs #(.CW(CW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_in (cnt_in),
        .cnt_q  (cnt_regs)
    );

    ack_gate_cntsel #(.CW(CW)) u_sel (
        .sel_rd    (sel_rd),
        .sel_first (accept),
        .cnt_regs  (cnt_regs),
        .cnt_sel   (cnt_sel),
        .cnt_zero  (cnt_zero)
    );

    ack_gate_down #(.CW(CW)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cnt_sel),
        .dec      (st_q == ST_HOLD),
        .cnt_q    (cnt_q),
        .at_one   (at_one)
    );

    ack_gate_beats #(.BEATS(BEATS)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .burst_in (burst_i),
        .adv      (beat_end),
        .last     (last_beat)
    );

    // Direction register, captured with the start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else if (accept) begin
            rd_q <= rd_i;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_nx = cnt_zero ? ST_SAMPLE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (at_one) begin
                    st_nx = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (ack_i) begin
                    if (last_beat) begin
                        st_nx = ST_LINE_END;
                    end else begin
                        st_nx = cnt_zero ? ST_SAMPLE : ST_HOLD;
                    end
                end
            end
            ST_LINE_END: begin
                st_nx = ST_IDLE;
            end
            default: begin
                st_nx = ST_IDLE;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        latch_o     = 1'b0;
        samp_o      = 1'b0;
        beat_done_o = 1'b0;
        line_done_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HOLD: begin
            end
            ST_SAMPLE: begin
                samp_o      = 1'b1;
                latch_o     = ack_i;
                beat_done_o = ack_i;
            end
            ST_LINE_END: begin
                line_done_o = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ack_gate_chk.sv
module ack_gate_chk
    import ack_gate_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          latch_o,
    input logic          samp_o,
    input logic          beat_done_o,
    input logic          line_done_o,
    input seq_state_t    st_q,
    input logic [CW-1:0] cnt_q
);

    // R3
    mask_while_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (!latch_o && !beat_done_o));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> (cnt_q == CW'($past(cnt_q) - CW'(1))));

    // R6
    latch_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_o |-> (ack_i && samp_o));

    // R8
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |=> !line_done_o);

    // R8
    line_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_done_o) |-> $past(beat_done_o));

    // R5
    samp_excl_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({samp_o, line_done_o}));

endmodule

bind ack_gate_seq ack_gate_chk #(.CW(CW)) u_ack_gate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .latch_o     (latch_o),
    .samp_o      (samp_o),
    .beat_done_o (beat_done_o),
    .line_done_o (line_done_o),
    .st_q        (st_q),
    .cnt_q       (cnt_q)
);

// File: tb/test_ack_gate_seq.sv
`timescale 1ns/1ps
module test_ack_gate_seq;

    localparam int CW    = 4;
    localparam int BEATS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, rd_i = 1'b0, burst_i = 1'b0, ack_i = 1'b0;
    logic [CW-1:0] rd_first_cnt_i = '0, rd_next_cnt_i = '0;
    logic [CW-1:0] wr_first_cnt_i = '0, wr_next_cnt_i = '0;
    logic latch_o, samp_o, beat_done_o, line_done_o;

    always #4 clk = ~clk;

    ack_gate_seq #(.CW(CW), .BEATS(BEATS)) i_ack_gate_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .burst_i(burst_i), .ack_i(ack_i),
        .rd_first_cnt_i(rd_first_cnt_i), .rd_next_cnt_i(rd_next_cnt_i),
        .wr_first_cnt_i(wr_first_cnt_i), .wr_next_cnt_i(wr_next_cnt_i),
        .latch_o(latch_o), .samp_o(samp_o),
        .beat_done_o(beat_done_o), .line_done_o(line_done_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state: 0 idle, 1 masked, 2 sampling, 3 line end.
    int m_ph = 0, m_cnt = 0, m_beat = 0;
    bit m_rd = 0, m_burst = 0;
    int k_rf = 0, k_rn = 0, k_wf = 0, k_wn = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int next_cnt(bit rd, bit first);
        if (rd) return first ? k_rf : k_rn;
        return first ? k_wf : k_wn;
    endfunction

    always @(posedge clk) begin
        cycles++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_beat = 0;
        end else begin
            case (m_ph)
                0: if (start_i) begin
                    m_rd = rd_i; m_burst = burst_i; m_beat = 0;
                    m_cnt = next_cnt(m_rd, 1'b1);
                    m_ph = (m_cnt == 0) ? 2 : 1;
                end
                1: begin
                    m_cnt--;
                    if (m_cnt == 0) m_ph = 2;
                end
                2: if (ack_i) begin
                    if (!m_burst || m_beat == BEATS - 1) m_ph = 3;
                    else begin
                        m_beat++;
                        m_cnt = next_cnt(m_rd, 1'b0);
                        m_ph = (m_cnt == 0) ? 2 : 1;
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every clock, mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 outputs in reset", {latch_o, samp_o, beat_done_o, line_done_o}, 0);
        end else begin
            check("R3 latch_o", latch_o, (m_ph == 2 && ack_i) ? 1 : 0);
            check("R6 beat_done_o", beat_done_o, (m_ph == 2 && ack_i) ? 1 : 0);
            check("R5 samp_o", samp_o, (m_ph == 2) ? 1 : 0);
            check("R8 line_done_o", line_done_o, (m_ph == 3) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset(input int rf, input int rn, input int wf, input int wn);
        @(posedge clk); #1;
        rst_n = 1'b0;
        rd_first_cnt_i = CW'(rf); rd_next_cnt_i = CW'(rn);
        wr_first_cnt_i = CW'(wf); wr_next_cnt_i = CW'(wn);
        k_rf = rf; k_rn = rn; k_wf = wf; k_wn = wn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: later changes to the count inputs must be ignored.
        rd_first_cnt_i = 4'd9; rd_next_cnt_i = 4'd7;
        wr_first_cnt_i = 4'd6; wr_next_cnt_i = 4'd5;
    endtask

    function automatic logic ack_of(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return lfsr[3];
            default: return (cyc > 5);
        endcase
    endfunction

    int last_latch = 0;

    // mode: 0 held, 1 pseudo-random, 2 late. exp_total < 0 skips that check.
    task automatic xfer(input bit rd, input bit bst, input int mode,
                        input bit busy_start, input int exp_total);
        int cyc = 0, first_samp = 0, beats = 0, exp_first;
        exp_first = next_cnt(rd, 1'b1) + 1;
        @(posedge clk); #1;
        start_i = 1'b1; rd_i = rd; burst_i = bst; ack_i = ack_of(mode, 0);
        @(posedge clk); #1;
        start_i = 1'b0;
        last_latch = 0;
        forever begin
            cyc++;
            ack_i = ack_of(mode, cyc);
            start_i = busy_start && (cyc == 2);
            rd_i = ~rd;
            burst_i = ~bst;
            @(negedge clk);
            if (samp_o && first_samp == 0) first_samp = cyc;
            if (beat_done_o) beats++;
            if (latch_o) last_latch = cyc;
            if (line_done_o || cyc > 300) break;
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        ack_i = 1'b0;
        check("R4 first sampling clock", first_samp, exp_first);
        check("R7 beats per transfer", beats, bst ? BEATS : 1);
        if (exp_total >= 0) check("R2 cycles to line done", cyc, exp_total);
    endtask

    initial begin
        do_reset(1, 1, 2, 0);
        @(negedge clk);
        check("R1 idle after reset", {latch_o, samp_o, beat_done_o, line_done_o}, 0);

        // R9: counts 1/1 with held acknowledge.
        xfer(1'b1, 1'b1, 0, 1'b0, 2 * BEATS + 1);
        check("R9 last latch clock counts 1", last_latch, 2 * BEATS);
        // Write pair 2/0: primary then back-to-back beats.
        xfer(1'b0, 1'b1, 0, 1'b0, 3 + (BEATS - 1) + 1);
        xfer(1'b0, 1'b1, 2, 1'b0, -1);
        xfer(1'b1, 1'b1, 1, 1'b1, -1);
        xfer(1'b1, 1'b0, 0, 1'b0, 2 + 1);
        xfer(1'b0, 1'b0, 1, 1'b0, -1);

        do_reset(0, 0, 5, 3);
        xfer(1'b1, 1'b1, 0, 1'b0, BEATS + 1);
        check("R9 last latch clock counts 0", last_latch, BEATS);
        xfer(1'b0, 1'b1, 0, 1'b1, 6 + 3 * 4 + 1);
        xfer(1'b0, 1'b1, 2, 1'b0, -1);
        xfer(1'b1, 1'b0, 1, 1'b0, -1);
        xfer(1'b0, 1'b1, 1, 1'b0, -1);

        do_reset(3, 2, 1, 4);
        xfer(1'b1, 1'b1, 1, 1'b0, -1);
        xfer(1'b0, 1'b0, 2, 1'b1, -1);
        xfer(1'b1, 1'b1, 0, 1'b0, 4 + 3 * 3 + 1);

        repeat (3) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule